// File: doc/BRIEF.md
# Watchdog Timer with Sleep-Aware Time-Out Action

This block is a watchdog counter that runs from its own low-power clock, separate from the system clock. Software must restart the count with a clear strobe before the counter rolls over. If the count does roll over, the block raises one of two requests. When the system is awake, it raises a reset request. When the system is asleep, it raises a wake request and does not reset. Because the counter sits in its own clock domain, it keeps counting when the system clock stops, and the time-out is delivered once that clock runs again.

The watchdog has two levels of enable. A non-volatile configuration bit, when set, turns the watchdog on permanently. When that bit is clear, a software enable bit decides whether the watchdog runs. A status flag in the system domain records that the most recent reset or wake request came from a watchdog time-out. Software clears the flag by a write, and the power-on reset also clears it.

The block has no data stream, so every pin is a plain control or status level or pulse; there is no valid/ready handshake. The clear strobe and both enable bits cross into the watchdog domain through two-flop synchronizers. A time-out event crosses back to the system domain as a toggle, so that no event is lost while either clock is slow or stopped. The watchdog clock must be slower than the system clock.

Top module: `wdsw_top`

## Requirements
- R1: With `cfg_wd_on` = 1 the watchdog counts and times out whatever value `sw_wd_on` has.
- R2: With `cfg_wd_on` = 0, `sw_wd_on` = 1 enables the watchdog and `sw_wd_on` = 0 disables it. While disabled, the count is held at zero and no request is raised.
- R3: With no clear strobe, an enabled watchdog times out after 2^CNT_W rising edges of `wd_clk`, counted from zero. No request appears earlier than that.
- R4: A `kick` pulse lasting one system cycle restarts the count from zero. Kicks repeated more often than the time-out period prevent every time-out.
- R5: A time-out while `asleep` = 0 gives exactly one `rst_req` pulse, one system cycle wide, and no `wake_req`.
- R6: A time-out while `asleep` = 1 gives exactly one `wake_req` pulse, one system cycle wide, and no `rst_req`. The two requests are never high together.
- R7: `to_flag` goes to 1 in the cycle a request pulse is issued. A one-cycle `flag_clr` write returns it to 0; if the write and a new time-out land in the same cycle, the time-out wins.
- R8: A time-out that happens while `sys_clk` is stopped is delivered as one request pulse after `sys_clk` resumes.
- R9: While `por_n` = 0, `rst_req`, `wake_req` and `to_flag` are 0, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| wd_clk | input | 1 | Independent low-power watchdog clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous, for both domains |
| cfg_wd_on | input | 1 | Non-volatile enable; 1 forces the watchdog on |
| sw_wd_on | input | 1 | Software enable, used only when `cfg_wd_on` = 0 |
| kick | input | 1 | Clear strobe, one system cycle per request |
| asleep | input | 1 | System sleep state, 1 = asleep |
| flag_clr | input | 1 | Software write that clears the status flag |
| rst_req | output | 1 | One-cycle reset request pulse (system domain) |
| wake_req | output | 1 | One-cycle wake request pulse (system domain) |
| to_flag | output | 1 | Time-out status flag |

## Verification
The hardest case to reach is a time-out that occurs while the system clock is halted. The counter must keep going and the event must wait in the crossing until the clock returns. The bench gates its own system clock off partway through a count and keeps it off past the roll-over. It then checks that no request appeared during the halt and that exactly one request appears after the clock restarts. Other stimulus uses randomly drawn combinations of enable and sleep values and random kick intervals below the period. Directed trials check the earliest and latest cycle at which a time-out may appear.

// File: rtl/wdsw_pkg.sv
package wdsw_pkg;
  // synchronizer depth for every crossing in the block
  localparam int unsigned SYNC_DEPTH = 2;

  // what a time-out turns into on the system side
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_WAKE  = 2'd2
  } wd_action_e;
endpackage

// File: rtl/wdsw_sync.sv
module wdsw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdsw_counter.sv
module wdsw_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic wd_clk,
  input  logic rst_n,
  input  logic en,
  input  logic kick_tgl_s,
  output logic evt_tgl
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic             kick_prev;
  logic             kick_hit;

  assign kick_hit = kick_tgl_s ^ kick_prev;

  always_ff @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      kick_prev <= 1'b0;
      evt_tgl   <= 1'b0;
    end else begin
      kick_prev <= kick_tgl_s;
      if (!en || kick_hit) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_TOP) evt_tgl <= ~evt_tgl;
      end
    end
  end

  // R2: disabled watchdog sits at zero
  a_r2_idle_zero: assert property (@(posedge wd_clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R4: a synchronized clear restarts the count
  a_r4_kick_zero: assert property (@(posedge wd_clk) disable iff (!rst_n)
    kick_hit |=> (cnt == '0));
  // R3: the event only moves on roll-over
  a_r3_no_early_evt: assert property (@(posedge wd_clk) disable iff (!rst_n)
    !(en && !kick_hit && cnt == CNT_TOP) |=> $stable(evt_tgl));
  a_r3_rollover_evt: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (en && !kick_hit && cnt == CNT_TOP) |=> (cnt == '0) && !$stable(evt_tgl));
endmodule

// File: rtl/wdsw_route.sv
module wdsw_route
  import wdsw_pkg::*;
(
  input  logic sys_clk,
  input  logic rst_n,
  input  logic evt_tgl_s,
  input  logic asleep,
  input  logic flag_clr,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag
);
  logic       evt_prev;
  wd_action_e act;

  always_comb begin
    act = ACT_NONE;
    if (evt_tgl_s ^ evt_prev) act = asleep ? ACT_WAKE : ACT_RESET;
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= 1'b0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      evt_prev <= evt_tgl_s;
      rst_req  <= (act == ACT_RESET);
      wake_req <= (act == ACT_WAKE);
      if (act != ACT_NONE) to_flag <= 1'b1;
      else if (flag_clr)   to_flag <= 1'b0;
    end
  end

  // R6: the two requests are exclusive
  a_r6_exclusive: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  // R6: wake only when asleep was seen
  a_r6_wake_asleep: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wake_req |-> $past(asleep));
  // R5: reset only when awake
  a_r5_reset_awake: assert property (@(posedge sys_clk) disable iff (!rst_n)
    rst_req |-> !$past(asleep));
  // R5: single-cycle pulses
  a_r5_one_cycle: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (rst_req || wake_req) |=> !(rst_req || wake_req));
  // R7: flag accompanies any request
  a_r7_flag_set: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> to_flag);
  a_r7_flag_fall: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(to_flag) |-> $past(flag_clr));
endmodule

// File: rtl/wdsw_top.sv
module wdsw_top
  import wdsw_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic sys_clk,
  input  logic wd_clk,
  input  logic por_n,
  input  logic cfg_wd_on,
  input  logic sw_wd_on,
  input  logic kick,
  input  logic asleep,
  input  logic flag_clr,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag
);
  localparam int unsigned XW = 3;  // cfg, sw, kick toggle

  logic          kick_tgl;
  logic [XW-1:0] x_s;
  logic          en_s;
  logic          evt_tgl;
  logic          evt_tgl_s;

  // a toggle carries a short strobe into the slower domain
  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n) kick_tgl <= 1'b0;
    else        kick_tgl <= kick_tgl ^ kick;
  end

  wdsw_sync #(.WIDTH(XW), .STAGES(SYNC_DEPTH)) u_to_wd (
    .clk   (wd_clk),
    .rst_n (por_n),
    .d     ({cfg_wd_on, sw_wd_on, kick_tgl}),
    .q     (x_s)
  );

  // hard configuration bit overrides the software bit
  assign en_s = x_s[2] | x_s[1];

  wdsw_counter #(.CNT_W(CNT_W)) u_cnt (
    .wd_clk     (wd_clk),
    .rst_n      (por_n),
    .en         (en_s),
    .kick_tgl_s (x_s[0]),
    .evt_tgl    (evt_tgl)
  );

  wdsw_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH)) u_to_sys (
    .clk   (sys_clk),
    .rst_n (por_n),
    .d     (evt_tgl),
    .q     (evt_tgl_s)
  );

  wdsw_route u_route (
    .sys_clk   (sys_clk),
    .rst_n     (por_n),
    .evt_tgl_s (evt_tgl_s),
    .asleep    (asleep),
    .flag_clr  (flag_clr),
    .rst_req   (rst_req),
    .wake_req  (wake_req),
    .to_flag   (to_flag)
  );

  // R1: configuration bit forces the synchronized enable on
  a_r1_cfg_forces: assert property (@(posedge wd_clk) disable iff (!por_n)
    x_s[2] |-> en_s);
endmodule

// File: tb/sim_wdsw_top.sv
module sim_wdsw_top;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned PERIOD = 1 << CNT_W;   // 64 wd edges
  localparam int unsigned EARLY = PERIOD - 9;    // no request before this
  localparam int unsigned LATE = PERIOD + 16;    // request seen by this

  logic sys_clk = 1'b0, wd_clk = 1'b0, sys_run = 1'b1;
  logic por_n = 1'b0, cfg_wd_on = 1'b0, sw_wd_on = 1'b0;
  logic kick = 1'b0, asleep = 1'b0, flag_clr = 1'b0;
  logic rst_req, wake_req, to_flag;

  int errors = 0, checks = 0;
  int n_rst = 0, n_wake = 0, n_long = 0, n_both = 0;
  logic prev_any = 1'b0;
  bit done = 1'b0;

  always begin #2.5; if (sys_run) sys_clk = ~sys_clk; end
  always #15 wd_clk = ~wd_clk;

  wdsw_top #(.CNT_W(CNT_W)) u0 (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .por_n(por_n),
    .cfg_wd_on(cfg_wd_on), .sw_wd_on(sw_wd_on), .kick(kick),
    .asleep(asleep), .flag_clr(flag_clr),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag));

  always @(negedge sys_clk) begin
    if (rst_req) n_rst++;
    if (wake_req) n_wake++;
    if (rst_req && wake_req) n_both++;
    if ((rst_req || wake_req) && prev_any) n_long++;
    prev_any = rst_req || wake_req;
  end

  function automatic bit exp_en(input bit c, input bit s);
    return c | s;
  endfunction
  function automatic int exp_resets(input bit c, input bit s, input bit slp);
    return (exp_en(c, s) && !slp) ? 1 : 0;
  endfunction
  function automatic int exp_wakes(input bit c, input bit s, input bit slp);
    return (exp_en(c, s) && slp) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wd_wait(input int n);
    repeat (n) @(posedge wd_clk);
  endtask

  task automatic do_kick();
    @(negedge sys_clk) kick = 1'b1;
    @(negedge sys_clk) kick = 1'b0;
  endtask

  task automatic do_flag_clr();
    @(negedge sys_clk) flag_clr = 1'b1;
    @(negedge sys_clk) flag_clr = 1'b0;
  endtask

  task automatic quiesce();
    @(negedge sys_clk);
    cfg_wd_on = 1'b0; sw_wd_on = 1'b0;
    wd_wait(10);
  endtask

  task automatic trial(input bit c, input bit s, input bit slp, input string tag);
    int r0, w0, er, ew;
    @(negedge sys_clk);
    cfg_wd_on = c; sw_wd_on = s; asleep = slp;
    do_kick();
    r0 = n_rst; w0 = n_wake;
    wd_wait(EARLY);
    chk((n_rst - r0) + (n_wake - w0) == 0, {tag, " R3 early"},
        (n_rst - r0) + (n_wake - w0), 0);
    wd_wait(LATE - EARLY);
    er = exp_resets(c, s, slp);
    ew = exp_wakes(c, s, slp);
    chk(n_rst - r0 == er, {tag, " R5 reset count"}, n_rst - r0, er);
    chk(n_wake - w0 == ew, {tag, " R6 wake count"}, n_wake - w0, ew);
    if (er + ew > 0) chk(to_flag == 1'b1, {tag, " R7 flag set"}, to_flag, 1);
    quiesce();
  endtask

  initial begin
    int r0, w0;
    void'($urandom(32'd1234));
    wd_wait(4);
    @(negedge sys_clk);
    chk(rst_req == 0 && wake_req == 0 && to_flag == 0, "R9 reset state",
        {rst_req, wake_req, to_flag}, 0);
    por_n = 1'b1;
    wd_wait(4);

    // R2: fully disabled, long wait
    r0 = n_rst; w0 = n_wake;
    wd_wait(3 * PERIOD);
    chk((n_rst - r0) + (n_wake - w0) == 0, "R2 disabled no request",
        (n_rst - r0) + (n_wake - w0), 0);

    // directed enables and sleep states
    trial(1'b1, 1'b0, 1'b0, "R1 cfg on sw off");
    trial(1'b0, 1'b1, 1'b0, "R2 sw on");
    trial(1'b1, 1'b1, 1'b1, "R6 asleep");

    // R7: clear write, then rearm
    do_flag_clr();
    @(negedge sys_clk);
    chk(to_flag == 1'b0, "R7 flag cleared", to_flag, 0);

    // random enable / sleep combinations
    for (int k = 0; k < 8; k++) begin
      bit c, s, slp;
      c = 1'($urandom % 2); s = 1'($urandom % 2); slp = 1'($urandom % 2);
      do_flag_clr();
      trial(c, s, slp, "R1 R2 random");
      if (!exp_en(c, s))
        chk(to_flag == 1'b0, "R2 random disabled flag", to_flag, 0);
    end

    // R4: random kicks under the period keep it quiet
    @(negedge sys_clk);
    cfg_wd_on = 1'b1; sw_wd_on = 1'b0; asleep = 1'b0;
    do_kick();
    r0 = n_rst; w0 = n_wake;
    for (int k = 0; k < 40; k++) begin
      wd_wait(1 + int'($urandom % (PERIOD - 20)));
      sw_wd_on = 1'($urandom % 2);
      do_kick();
    end
    chk((n_rst - r0) + (n_wake - w0) == 0, "R4 kicks prevent time-out",
        (n_rst - r0) + (n_wake - w0), 0);
    // then kicks stop: time-out must follow
    wd_wait(LATE);
    chk(n_rst - r0 == 1, "R4 time-out after kicks stop", n_rst - r0, 1);
    quiesce();

    // R8: roll-over while sys_clk is halted
    @(negedge sys_clk);
    cfg_wd_on = 1'b1; asleep = 1'b0;
    do_kick();
    r0 = n_rst; w0 = n_wake;
    wd_wait(5);
    sys_run = 1'b0;
    wd_wait(PERIOD + 25);
    chk(n_rst - r0 == 0, "R8 nothing while halted", n_rst - r0, 0);
    sys_run = 1'b1;
    repeat (12) @(negedge sys_clk);
    cfg_wd_on = 1'b0;
    chk(n_rst - r0 == 1, "R8 delivered after resume", n_rst - r0, 1);
    chk(n_wake - w0 == 0, "R8 no wake", n_wake - w0, 0);
    quiesce();

    chk(n_long == 0, "R5 one-cycle pulses", n_long, 0);
    chk(n_both == 0, "R6 exclusive requests", n_both, 0);

    // R9: power-on reset clears the flag
    chk(to_flag == 1'b1, "R9 flag set before reset", to_flag, 1);
    @(negedge sys_clk) por_n = 1'b0;
    @(negedge sys_clk);
    chk(to_flag == 1'b0, "R9 flag cleared by reset", to_flag, 0);
    por_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(800us);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule